// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block runs programmed-I/O register cycles on a parallel ATA drive bus from the host side. A CPU-side agent presents one request at a time: a 4-bit register address, a read or write direction, a byte-or-word width flag and the write data. While the bus cycle runs, the engine raises a busy flag. When the cycle ends it pulses a completion strobe and holds the captured read data.

Every phase of a cycle is counted in clocks. The counts come from two packed 32-bit timing words that software fills with nanosecond minimums already rounded up to whole clocks. The phases are address setup, active strobe, data hold, and an idle tail. The idle tail enforces both the minimum cycle length and the recovery time after the strobe. The active width comes from one field for byte (taskfile) accesses and from a different field for word (data register) accesses. An optional flow-control input from the drive can stretch the strobe.

A configuration word carries a state-machine reset bit and a flow-control enable bit. A share word sets the length of a free-running bus time slot. The engine emits a single-clock tick at the end of each slot.

Top module: `pio_cycle_engine`

## Requirements
- R1: After rst_n is released, and whenever busy is 0, both strobes (active low) are high, ata_cs_n is 2'b11, ata_data_oe is 0, and slot_tick stays 0 while share_word[31:16] is 0.
- R2: A request is accepted when req_valid is 1 and busy is 0. Busy then rises for the cycle. First comes an address setup phase of S = max(tim_word_b[23:16], 1) clocks with the strobe high. Then exactly one strobe (ata_rd_n for reads, ata_wr_n for writes) is low for the active phase. After that the address stays driven for a hold phase of tim_word_b[31:24] clocks.
- R3: The active phase lasts A = max(field, 1) clocks. The field is tim_word_a[23:16] when req_wide = 0 (byte access) and tim_word_a[15:8] when req_wide = 1 (word access).
- R4: The cycle lasts max(S+A+H, tim_word_a[31:24], S+A+tim_word_a[7:0]) clocks of busy, where H is the hold count. A recovery field (bits 7:0) of 0 adds no idle time.
- R5: When cfg_word[24] = 1 and ata_iordy is low at a clock at least tim_word_b[15:8] clocks into the strobe, the strobe is extended until a clock in which ata_iordy is high. When cfg_word[24] = 0, ata_iordy has no effect on timing. When tim_word_b[15:8] is at least A, ata_iordy also has no effect on timing.
- R6: Read data is captured from ata_data_in on the clock edge that ends the strobe. A byte read returns {8'h00, ata_data_in[7:0]} on rsp_rdata.
- R7: For writes, ata_data_oe is 1 from setup through the end of hold and 0 after that. ata_data_out carries req_wdata for word writes and {8'h00, req_wdata[7:0]} for byte writes. Reads never enable the data bus.
- R8: While cfg_word[31] is 1, a cycle in progress is abandoned: busy is 0 one clock later, the strobes are high, and requests are not accepted.
- R9: Requests presented while busy is 1 are dropped. They neither change the address of the running cycle nor start a later cycle.
- R10: With L = share_word[31:16] nonzero, slot_tick pulses for one clock every L clocks. With L = 0 it stays low.
- R11: During setup, active and hold, ata_addr equals req_addr[2:0]. ata_cs_n is 2'b10 when req_addr[3] = 0 and 2'b01 when req_addr[3] = 1. Both chip selects are never low at once.
- R12: rsp_done is 1 for exactly one clock, on the clock in which busy has just fallen at the normal end of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Bit 31 state-machine reset, bit 24 flow-control enable |
| tim_word_a | input | 32 | Cycle time, byte active, word active, recovery |
| tim_word_b | input | 32 | Hold, setup, flow-control window; bits 7:0 unused |
| share_word | input | 32 | Bits 31:16 slot length in clocks |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write cycle |
| req_wide | input | 1 | 1 = 16-bit data register access |
| req_addr | input | 4 | Bit 3 chip-select choice, bits 2:0 register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_addr | output | 3 | Drive register address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_data_oe | output | 1 | Data bus output enable |
| ata_data_out | output | 16 | Data bus value driven |
| ata_data_in | input | 16 | Data bus value sampled |
| ata_iordy | input | 1 | Drive ready for flow control |
| slot_tick | output | 1 | End-of-slot pulse |

## Verification
A counter or phase register that is wrong inside the engine shows up on the bus pins within the same cycle. The setup, strobe and busy lengths change by one or more clocks, so the bench measures each phase clock by clock rather than only checking the end result. A capture at the wrong edge appears on rsp_rdata at completion, because the bench changes ata_data_in outside the strobe. Flow-control mistakes appear as a strobe of the wrong length, and an abort fault appears one clock after the reset bit rises.

// File: rtl/pio_eng_pkg.sv
`timescale 1ns/1ps
package pio_eng_pkg;
    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] cycle;
        logic [FIELD_W-1:0] act_byte;
        logic [FIELD_W-1:0] act_word;
        logic [FIELD_W-1:0] recover;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] rdy_win;
    } pio_timing_t;
endpackage

// File: rtl/pio_timing_unpack.sv
`timescale 1ns/1ps
module pio_timing_unpack
    import pio_eng_pkg::*;
(
    input  logic [31:0] word_a,
    input  logic [31:0] word_b,
    output pio_timing_t tim
);
    // Field positions are fixed by the software that packs the words.
    always_comb begin
        tim.cycle    = word_a[31:24];
        tim.act_byte = word_a[23:16];
        tim.act_word = word_a[15:8];
        tim.recover  = word_a[7:0];
        tim.hold     = word_b[31:24];
        tim.setup    = word_b[23:16];
        tim.rdy_win  = word_b[15:8];
    end

    logic unused_low;
    assign unused_low = ^word_b[7:0];
endmodule

// File: rtl/pio_slot_timer.sv
`timescale 1ns/1ps
module pio_slot_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] slot_len,
    output logic             tick
);
    localparam logic [LEN_W:0] ONE_X = 1;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             tick;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (slot_len == '0) begin
            s_d.cnt = '0;
        end else if (({1'b0, s_q.cnt} + ONE_X) >= {1'b0, slot_len}) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/pio_cycle_engine.sv
`timescale 1ns/1ps
module pio_cycle_engine
    import pio_eng_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic [31:0]       tim_word_a,
    input  logic [31:0]       tim_word_b,
    input  logic [31:0]       share_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        ata_cs_n,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic              ata_data_oe,
    output logic [DATA_W-1:0] ata_data_out,
    input  logic [DATA_W-1:0] ata_data_in,
    input  logic              ata_iordy,
    output logic              slot_tick
);
    localparam int BYTE_W = 8;
    localparam int FW     = FIELD_W;
    localparam int PAD_W  = CNT_W - FW;
    localparam logic [CNT_W:0] CNT_ONE = 1;

    // Does a counter that has completed n clocks reach lim after this clock?
    function automatic logic reached(input logic [CNT_W-1:0] n, input logic [FW-1:0] lim);
        return ({1'b0, n} + CNT_ONE) >= {{(PAD_W + 1){1'b0}}, lim};
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] n);
        return (n == '1) ? n : n + CNT_W'(1);
    endfunction

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  pcnt;
        logic [CNT_W-1:0]  tot;
        logic [CNT_W-1:0]  post;
        logic              wr;
        logic              wide;
        logic [ADDR_W:0]   addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } eng_t;

    pio_timing_t tim;
    eng_t        s_d, s_q;

    logic sm_reset, rdy_en, drive;
    logic [FW-1:0] act_len, act_min, set_min;
    logic stall, fin_tail;
    logic [DATA_W-1:0] cap_data;

    assign sm_reset = cfg_word[31];
    assign rdy_en   = cfg_word[24];

    logic unused_cfg;
    assign unused_cfg = ^{cfg_word[30:25], cfg_word[23:0], share_word[15:0]};

    pio_timing_unpack unpack_i (
        .word_a (tim_word_a),
        .word_b (tim_word_b),
        .tim    (tim)
    );

    pio_slot_timer #(.LEN_W(SLOT_W)) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_len (share_word[31:31-SLOT_W+1]),
        .tick     (slot_tick)
    );

    always_comb begin
        act_len  = s_q.wide ? tim.act_word : tim.act_byte;
        act_min  = (act_len == '0) ? FW'(1) : act_len;
        set_min  = (tim.setup == '0) ? FW'(1) : tim.setup;
        stall    = rdy_en && ({{PAD_W{1'b0}}, tim.rdy_win} <= s_q.pcnt) && !ata_iordy;
        fin_tail = reached(s_q.tot, tim.cycle) && reached(s_q.post, tim.recover);
        cap_data = s_q.wide ? ata_data_in
                            : {{(DATA_W-BYTE_W){1'b0}}, ata_data_in[BYTE_W-1:0]};

        s_d      = s_q;
        s_d.done = 1'b0;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph    = PH_SETUP;
                    s_d.pcnt  = '0;
                    s_d.tot   = '0;
                    s_d.post  = '0;
                    s_d.wr    = req_write;
                    s_d.wide  = req_wide;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wide ? req_wdata
                                         : {{(DATA_W-BYTE_W){1'b0}}, req_wdata[BYTE_W-1:0]};
                end
            end
            PH_SETUP: begin
                s_d.tot = sat_inc(s_q.tot);
                if (reached(s_q.pcnt, set_min)) begin
                    s_d.ph   = PH_ACTIVE;
                    s_d.pcnt = '0;
                end else begin
                    s_d.pcnt = sat_inc(s_q.pcnt);
                end
            end
            PH_ACTIVE: begin
                s_d.tot = sat_inc(s_q.tot);
                if (reached(s_q.pcnt, act_min) && !stall) begin
                    s_d.rdata = cap_data;
                    s_d.post  = '0;
                    s_d.pcnt  = '0;
                    if (tim.hold != '0) begin
                        s_d.ph = PH_HOLD;
                    end else if (reached(s_q.tot, tim.cycle) && tim.recover == '0) begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph = PH_RECOV;
                    end
                end else begin
                    s_d.pcnt = sat_inc(s_q.pcnt);
                end
            end
            PH_HOLD: begin
                s_d.tot  = sat_inc(s_q.tot);
                s_d.post = sat_inc(s_q.post);
                if (reached(s_q.pcnt, tim.hold)) begin
                    s_d.pcnt = '0;
                    if (fin_tail) begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph = PH_RECOV;
                    end
                end else begin
                    s_d.pcnt = sat_inc(s_q.pcnt);
                end
            end
            PH_RECOV: begin
                s_d.tot  = sat_inc(s_q.tot);
                s_d.post = sat_inc(s_q.post);
                if (fin_tail) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase

        if (sm_reset) begin
            s_d.ph   = PH_IDLE;
            s_d.pcnt = '0;
            s_d.tot  = '0;
            s_d.post = '0;
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drive        = (s_q.ph == PH_SETUP) || (s_q.ph == PH_ACTIVE) || (s_q.ph == PH_HOLD);
    assign busy         = (s_q.ph != PH_IDLE);
    assign rsp_done     = s_q.done;
    assign rsp_rdata    = s_q.rdata;
    assign ata_cs_n     = !drive ? 2'b11 : (s_q.addr[ADDR_W] ? 2'b01 : 2'b10);
    assign ata_addr     = drive ? s_q.addr[ADDR_W-1:0] : '0;
    assign ata_rd_n     = !((s_q.ph == PH_ACTIVE) && !s_q.wr);
    assign ata_wr_n     = !((s_q.ph == PH_ACTIVE) && s_q.wr);
    assign ata_data_oe  = drive && s_q.wr;
    assign ata_data_out = s_q.wdata;
endmodule

// File: rtl/pio_cycle_engine_chk.sv
`timescale 1ns/1ps
module pio_cycle_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sm_reset,
    input logic       busy,
    input logic       done,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] cs_n,
    input logic       oe
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !oe && cs_n == 2'b11));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_rd_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(cs_n) != 2'b11);

    assert_wr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(cs_n) != 2'b11);

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sm_reset |=> !busy);

    assert_cs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));
endmodule

bind pio_cycle_engine pio_cycle_engine_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sm_reset (cfg_word[31]),
    .busy     (busy),
    .done     (rsp_done),
    .rd_n     (ata_rd_n),
    .wr_n     (ata_wr_n),
    .cs_n     (ata_cs_n),
    .oe       (ata_data_oe)
);

// File: tb/pio_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module pio_cycle_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0, tim_word_a = '0, tim_word_b = '0, share_word = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_done, ata_rd_n, ata_wr_n, ata_data_oe, slot_tick;
    logic [15:0] rsp_rdata, ata_data_out;
    logic [15:0] ata_data_in = '0;
    logic        ata_iordy = 1'b1;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_addr;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [7:0] g_t0, g_a8, g_a16, g_t2i, g_t4, g_t1, g_ta;

    always #10 clk = ~clk;

    pio_cycle_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tim_word_a(tim_word_a),
        .tim_word_b(tim_word_b), .share_word(share_word), .req_valid(req_valid),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ata_cs_n(ata_cs_n), .ata_addr(ata_addr), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
        .ata_data_oe(ata_data_oe), .ata_data_out(ata_data_out), .ata_data_in(ata_data_in),
        .ata_iordy(ata_iordy), .slot_tick(slot_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic set_tim(input int t0, input int a8, input int a16, input int t2i,
                           input int t4, input int t1, input int ta);
        g_t0 = 8'(t0); g_a8 = 8'(a8); g_a16 = 8'(a16); g_t2i = 8'(t2i);
        g_t4 = 8'(t4); g_t1 = 8'(t1); g_ta = 8'(ta);
        tim_word_a = {g_t0, g_a8, g_a16, g_t2i};
        tim_word_b = {g_t4, g_t1, g_ta, 8'h00};
    endtask

    // One full bus cycle, measured clock by clock at the falling edge.
    task automatic do_cycle(input string nm, input bit wr, input bit wide,
                            input logic [3:0] addr, input logic [15:0] wd,
                            input logic [15:0] rdin, input bit ien, input bit rdy_low,
                            input int rel, input bit poke);
        int s_exp, a_min, a_exp, n_exp, drive_end;
        int n_set = 0, n_act = 0, n_tot = 0, bad_sel = 0, bad_dat = 0, bad_strb = 0;
        logic [15:0] exp_out, exp_rd;
        logic [1:0]  exp_cs;
        bit strb, other;
        s_exp = (g_t1 == 0) ? 1 : int'(g_t1);
        a_min = wide ? int'(g_a16) : int'(g_a8);
        if (a_min == 0) a_min = 1;
        a_exp = a_min;
        if (ien && rdy_low && rel >= 0 && int'(g_ta) < a_min) a_exp = imax(a_min, rel - s_exp + 1);
        drive_end = s_exp + a_exp + int'(g_t4);
        n_exp = imax(imax(drive_end, int'(g_t0)), s_exp + a_exp + int'(g_t2i));
        exp_cs  = addr[3] ? 2'b01 : 2'b10;
        exp_out = wide ? wd : {8'h00, wd[7:0]};
        exp_rd  = wide ? rdin : {8'h00, rdin[7:0]};

        @(negedge clk);
        cfg_word    = {7'b0, ien, 24'b0};
        ata_iordy   = !rdy_low;
        ata_data_in = ~rdin;
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 4000; j++) begin
            if (!busy) break;
            n_tot++;
            strb  = wr ? !ata_wr_n : !ata_rd_n;
            other = wr ? !ata_rd_n : !ata_wr_n;
            if (other) bad_strb++;
            if (strb) begin
                n_act++;
                ata_data_in = rdin;
            end else begin
                if (n_act == 0) n_set++;
                ata_data_in = ~rdin;
            end
            if (j < drive_end) begin
                if (ata_cs_n != exp_cs || ata_addr != addr[2:0]) bad_sel++;
                if (ata_data_oe != wr || (wr && ata_data_out != exp_out)) bad_dat++;
            end else begin
                if (ata_cs_n != 2'b11) bad_sel++;
                if (ata_data_oe) bad_dat++;
            end
            if (j == rel) ata_iordy = 1'b1;
            if (poke && j == 1) begin
                req_valid = 1'b1; req_addr = 4'b1001; req_write = !wr;
            end
            if (poke && j == 2) req_valid = 1'b0;
            @(negedge clk);
        end
        check(n_set == s_exp, $sformatf("%s R2 setup clocks", nm), n_set, s_exp);
        check(n_act == a_exp, $sformatf("%s R3 R5 active clocks", nm), n_act, a_exp);
        check(n_tot == n_exp, $sformatf("%s R4 busy clocks", nm), n_tot, n_exp);
        check(bad_strb == 0, $sformatf("%s R2 wrong strobe", nm), bad_strb, 0);
        check(bad_sel == 0, $sformatf("%s R11 select and address", nm), bad_sel, 0);
        check(bad_dat == 0, $sformatf("%s R7 write bus", nm), bad_dat, 0);
        check(rsp_done == 1'b1, $sformatf("%s R12 done pulse", nm), int'(rsp_done), 1);
        if (!wr)
            check(rsp_rdata == exp_rd, $sformatf("%s R6 read data", nm), int'(rsp_rdata), int'(exp_rd));
        if (poke) begin
            @(negedge clk);
            check(!busy && !rsp_done, $sformatf("%s R9 request while busy dropped", nm), int'(busy), 0);
        end
        ata_iordy = 1'b1;
    endtask

    task automatic t_reset_state;
        check(!busy, "R1 busy after reset", int'(busy), 0);
        check(ata_rd_n && ata_wr_n, "R1 strobes high", int'({ata_rd_n, ata_wr_n}), 3);
        check(ata_cs_n == 2'b11 && !ata_data_oe, "R1 selects and bus idle",
              int'({ata_cs_n, ata_data_oe}), 6);
        check(!slot_tick, "R1 no slot tick", int'(slot_tick), 0);
    endtask

    task automatic t_abort;
        int bad = 0;
        set_tim(12, 3, 5, 0, 1, 2, 1);
        @(negedge clk);
        cfg_word = '0;
        req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b1; req_addr = 4'b0000; req_wdata = 16'h7E81;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!ata_wr_n, "R2 strobe low before abort", int'(ata_wr_n), 0);
        cfg_word[31] = 1'b1;
        @(negedge clk);
        check(!busy && ata_wr_n && !ata_data_oe && ata_cs_n == 2'b11, "R8 abort clears cycle",
              int'({busy, ata_wr_n, ata_data_oe}), 2);
        req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (busy) bad++;
        end
        check(bad == 0, "R8 requests blocked in reset", bad, 0);
        req_valid = 1'b0;
        cfg_word = '0;
        @(negedge clk);
        check(!busy && !rsp_done, "R8 no cycle after release", int'({busy, rsp_done}), 0);
    endtask

    task automatic t_slot;
        int ticks = 0, last = -1, gap = 0;
        share_word = {16'd5, 16'd0};
        repeat (3) @(negedge clk);
        for (int k = 0; k < 50; k++) begin
            if (slot_tick) begin
                ticks++;
                if (last >= 0) gap = k - last;
                last = k;
            end
            @(negedge clk);
        end
        check(ticks == 10, "R10 tick count over 50 clocks", ticks, 10);
        check(gap == 5, "R10 tick spacing", gap, 5);
        share_word = '0;
        repeat (2) @(negedge clk);
        ticks = 0;
        for (int k = 0; k < 30; k++) begin
            if (slot_tick) ticks++;
            @(negedge clk);
        end
        check(ticks == 0, "R10 zero length gives no tick", ticks, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        set_tim(12, 3, 5, 0, 1, 2, 1);
        do_cycle("byte_rd", 1'b0, 1'b0, 4'b0111, 16'h0000, 16'hA55A, 1'b0, 1'b0, -1, 1'b0);
        do_cycle("word_wr", 1'b1, 1'b1, 4'b0000, 16'hBEEF, 16'h0000, 1'b0, 1'b0, -1, 1'b1);
        set_tim(4, 2, 4, 7, 3, 0, 1);
        do_cycle("byte_wr_recov", 1'b1, 1'b0, 4'b1110, 16'h12C3, 16'h0000, 1'b0, 1'b0, -1, 1'b0);
        do_cycle("word_rd_recov", 1'b0, 1'b1, 4'b1000, 16'h0000, 16'h8001, 1'b0, 1'b0, -1, 1'b0);
        set_tim(0, 2, 2, 0, 0, 1, 0);
        do_cycle("no_tail", 1'b0, 1'b0, 4'b0011, 16'h0000, 16'h3CC3, 1'b0, 1'b0, -1, 1'b0);
        set_tim(12, 3, 5, 0, 1, 2, 1);
        do_cycle("rdy_stretch", 1'b0, 1'b0, 4'b0001, 16'h0000, 16'h0F0F, 1'b1, 1'b1, 12, 1'b0);
        do_cycle("rdy_off", 1'b0, 1'b0, 4'b0010, 16'h0000, 16'h00F0, 1'b0, 1'b1, -1, 1'b0);
        set_tim(12, 3, 5, 0, 1, 2, 4);
        do_cycle("rdy_window", 1'b1, 1'b0, 4'b0101, 16'h0066, 16'h0000, 1'b1, 1'b1, -1, 1'b0);
        t_abort();
        set_tim(12, 3, 5, 0, 1, 2, 1);
        do_cycle("after_abort", 1'b0, 1'b1, 4'b1010, 16'h0000, 16'h5AA5, 1'b0, 1'b0, -1, 1'b0);
        t_slot();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule